// File: doc/BRIEF.md
# Multi-Region Instruction Dispatch Arbiter

This block is the issue stage of an instruction region that feeds N execution regions. The instruction store presents a fetch group of up to N instruction slots. Each slot carries a valid bit, a target-region field and an instruction payload. The block takes a group only when it holds nothing, and it keeps that group as a pending mask. It forwards each pending instruction to its target region over a request/acknowledge channel, and only when that region says it can accept work. Slots clear one at a time as their acknowledges arrive. When the last one clears, the block advances its fetch address by the number of valid slots in the group and takes the next group.

Several slots may compete for the same region. By default they go in ascending slot order. With the randomized mode on, each region uses a rotating priority whose starting slot comes from a free-running 16-bit LFSR. The issue order inside a region then changes from group to group, which makes the execution schedule harder to observe from outside. Channels to different regions are independent, so one cycle can issue to several regions at once.

Top module: `dispatch_arbiter`

## Requirements
- R1: `grp_take` is high in exactly those cycles in which no group is held and `grp_valid` is high. The group on the inputs is captured at the edge that ends such a cycle.
- R2: Slot i sits at bits [i*IW +: IW] of `grp_insn`, its target at bits [i*TW +: TW] of `grp_tgt`, and its valid bit at `grp_slot_vld[i]`. Every valid slot of a held group is issued exactly once, on channel r equal to its target field, and invalid slots are never issued.
- R3: A channel's request rises only at a clock edge at which that region's `reg_rdy` was high.
- R4: While `reg_req[r]` is high and `reg_ack[r]` is low, the request stays high at the next edge and `reg_insn` for that channel keeps its value.
- R5: After an edge at which request and acknowledge were both high, the request is low for at least the following cycle.
- R6: A held group is never replaced while any of its valid slots is unacknowledged, and no new group is taken in that time.
- R7: In the cycle after the edge that acknowledges the last valid slot, `pc_adv` is high for one cycle, `pc_step` equals the number of valid slots, and `fetch_pc` has grown by that number (modulo 2^PC_W). A group with no valid slot completes one cycle after capture with a step of 0. `fetch_pc` changes at no other time.
- R8: With `rand_en` low, slots that target the same region are issued in ascending slot index order.
- R9: With `rand_en` high, the starting slot of each region's rotating priority comes from a 16-bit LFSR that steps every cycle. Over many competing groups, at least one region then receives its slots in an order that is not ascending.
- R10: During reset all requests and `pc_adv` are low and `fetch_pc` is 0. The LFSR is loaded with a nonzero seed and never becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rand_en | input | 1 | Randomized issue order among competing slots |
| grp_valid | input | 1 | Instruction store presents a fetch group |
| grp_slot_vld | input | N | Per-slot valid bits |
| grp_tgt | input | N*TW | Per-slot target region index |
| grp_insn | input | N*IW | Per-slot instruction payload |
| grp_take | output | 1 | Group on the inputs is captured at the next edge |
| fetch_pc | output | PC_W | Address of the next group to fetch |
| pc_adv | output | 1 | One-cycle pulse on group completion |
| pc_step | output | CW | Number of valid slots in the completed group |
| reg_rdy | input | N | Region r can accept an instruction |
| reg_ack | input | N | Region r accepts the instruction on its channel |
| reg_req | output | N | Request to region r |
| reg_insn | output | N*IW | Payload offered to region r |

## Verification
The assertions check the per-cycle channel rules on every cycle: a request rises only after ready, it holds with a stable payload until its acknowledge, and it drops after that acknowledge. They also check that an issued slot is always still pending, that the group registers stay frozen while work is pending, that the fetch address moves only on completion and by the step it reports, and that the LFSR never locks at zero. Some properties need whole scenarios from the bench, which tracks each group from capture to completion. These are exactly-once delivery to the right region, ascending order in deterministic mode, and the exact completion cycle and step. Most of all, only the bench can show that randomized mode really reorders competing slots.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
    localparam int MAX_SLOTS = 32;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } chan_state_e;

    typedef struct packed {
        logic       found;
        logic [4:0] idx;
    } pick_t;

    // Maximal-length polynomial x^16 + x^14 + x^13 + x^11 + 1
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[14:0], fb};
    endfunction

    // First set bit of cand[0..n-1], scanning from slot 'start' upward with wrap
    function automatic pick_t rot_first(input logic [MAX_SLOTS-1:0] cand,
                                        input int n, input int start);
        pick_t r;
        int    i;
        r = '0;
        for (int k = MAX_SLOTS - 1; k >= 0; k--) begin
            if (k < n) begin
                i = (start + k) % n;
                if (cand[i]) begin
                    r.found = 1'b1;
                    r.idx   = 5'(i);
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/disp_lfsr.sv
module disp_lfsr
    import dispatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [LFSR_W-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst)
            state <= LFSR_SEED;
        else if (en)
            state <= lfsr_next(state);
    end

    a_r10_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        state != '0)
        else $error("LFSR reached the all-zero state");

endmodule

// File: rtl/disp_group_hold.sv
module disp_group_hold #(
    parameter int N    = 4,
    parameter int IW   = 16,
    parameter int PC_W = 16,
    parameter int TW   = (N > 1) ? $clog2(N) : 1,
    parameter int CW   = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            grp_valid,
    input  logic [N-1:0]    grp_slot_vld,
    input  logic [N*TW-1:0] grp_tgt,
    input  logic [N*IW-1:0] grp_insn,
    input  logic [N-1:0]    acc_all,
    output logic            grp_take,
    output logic [N-1:0]    pend,
    output logic [N*TW-1:0] tgt_q,
    output logic [N*IW-1:0] insn_q,
    output logic [PC_W-1:0] fetch_pc,
    output logic            pc_adv,
    output logic [CW-1:0]   pc_step
);

    logic          live;
    logic [CW-1:0] size_q;
    logic [N-1:0]  pend_nx;

    assign grp_take = !live && grp_valid;
    assign pend_nx  = pend & ~acc_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            live     <= 1'b0;
            pend     <= '0;
            tgt_q    <= '0;
            insn_q   <= '0;
            size_q   <= '0;
            fetch_pc <= '0;
            pc_adv   <= 1'b0;
            pc_step  <= '0;
        end else begin
            pc_adv <= 1'b0;
            if (!live) begin
                if (grp_valid) begin
                    live   <= 1'b1;
                    pend   <= grp_slot_vld;
                    tgt_q  <= grp_tgt;
                    insn_q <= grp_insn;
                    size_q <= CW'($countones(grp_slot_vld));
                end
            end else begin
                pend <= pend_nx;
                if (pend_nx == '0) begin
                    live     <= 1'b0;
                    fetch_pc <= fetch_pc + PC_W'(size_q);
                    pc_adv   <= 1'b1;
                    pc_step  <= size_q;
                end
            end
        end
    end

    a_r6_group_frozen: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |=> ($stable(tgt_q) && $stable(insn_q)))
        else $error("held group changed while slots pending");

    a_r7_pc_only_on_done: assert property (@(posedge clk) disable iff (rst)
        !(live && pend_nx == '0) |=> $stable(fetch_pc))
        else $error("fetch address moved without completion");

    a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
        pc_adv |-> (fetch_pc == $past(fetch_pc) + PC_W'(pc_step)))
        else $error("fetch address advanced by wrong amount");

    a_r7_adv_pulse: assert property (@(posedge clk) disable iff (rst)
        pc_adv |=> !pc_adv)
        else $error("advance pulse longer than one cycle");

endmodule

// File: rtl/disp_region_port.sv
module disp_region_port
    import dispatch_pkg::*;
#(
    parameter int N   = 4,
    parameter int IW  = 16,
    parameter int RID = 0,
    parameter int TW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    pend,
    input  logic [N*TW-1:0] tgt_q,
    input  logic [N*IW-1:0] insn_q,
    input  logic [TW-1:0]   start,
    input  logic            rdy,
    input  logic            ack,
    output logic            req,
    output logic [IW-1:0]   insn_out,
    output logic [N-1:0]    acc
);

    chan_state_e    st;
    logic [TW-1:0]  slot;
    logic [N-1:0]   cand;
    pick_t          pick;

    always_comb begin
        for (int i = 0; i < N; i++)
            cand[i] = pend[i] && (tgt_q[i*TW +: TW] == TW'(RID));
        pick = rot_first(MAX_SLOTS'(cand), N, int'(start));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= CH_IDLE;
            slot <= '0;
        end else begin
            case (st)
                CH_IDLE: if (rdy && pick.found) begin
                    st   <= CH_BUSY;
                    slot <= TW'(pick.idx);
                end
                CH_BUSY: if (ack) st <= CH_IDLE;
                default: st <= CH_IDLE;
            endcase
        end
    end

    assign req      = (st == CH_BUSY);
    assign insn_out = insn_q[slot*IW +: IW];

    always_comb begin
        acc = '0;
        if (st == CH_BUSY && ack)
            acc[slot] = 1'b1;
    end

    a_r3_ready_first: assert property (@(posedge clk) disable iff (rst)
        (!req && !rdy) |=> !req)
        else $error("request raised without ready");

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(insn_out)))
        else $error("request or payload changed before acknowledge");

    a_r5_drop: assert property (@(posedge clk) disable iff (rst)
        (req && ack) |=> !req)
        else $error("request did not drop after acknowledge");

    a_r2_issued_pending: assert property (@(posedge clk) disable iff (rst)
        req |-> (pend[slot] && tgt_q[slot*TW +: TW] == TW'(RID)))
        else $error("issued slot not pending for this region");

endmodule

// File: rtl/dispatch_arbiter.sv
module dispatch_arbiter
    import dispatch_pkg::*;
#(
    parameter int N    = 4,
    parameter int IW   = 16,
    parameter int PC_W = 16,
    parameter int TW   = (N > 1) ? $clog2(N) : 1,
    parameter int CW   = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rand_en,
    input  logic            grp_valid,
    input  logic [N-1:0]    grp_slot_vld,
    input  logic [N*TW-1:0] grp_tgt,
    input  logic [N*IW-1:0] grp_insn,
    output logic            grp_take,
    output logic [PC_W-1:0] fetch_pc,
    output logic            pc_adv,
    output logic [CW-1:0]   pc_step,
    input  logic [N-1:0]    reg_rdy,
    input  logic [N-1:0]    reg_ack,
    output logic [N-1:0]    reg_req,
    output logic [N*IW-1:0] reg_insn
);

    logic [N-1:0]          pend;
    logic [N*TW-1:0]       tgt_q;
    logic [N*IW-1:0]       insn_q;
    logic [N-1:0]          acc_all;
    logic [N-1:0][N-1:0]   acc_r;
    logic [N-1:0][TW-1:0]  start_v;
    logic [LFSR_W-1:0]     lfsr;

    disp_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .en    (rand_en),
        .state (lfsr)
    );

    disp_group_hold #(.N(N), .IW(IW), .PC_W(PC_W), .TW(TW), .CW(CW)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .grp_valid    (grp_valid),
        .grp_slot_vld (grp_slot_vld),
        .grp_tgt      (grp_tgt),
        .grp_insn     (grp_insn),
        .acc_all      (acc_all),
        .grp_take     (grp_take),
        .pend         (pend),
        .tgt_q        (tgt_q),
        .insn_q       (insn_q),
        .fetch_pc     (fetch_pc),
        .pc_adv       (pc_adv),
        .pc_step      (pc_step)
    );

    always_comb begin
        acc_all = '0;
        for (int r = 0; r < N; r++) begin
            acc_all   = acc_all | acc_r[r];
            start_v[r] = rand_en ? TW'((32'(lfsr) + 32'(r)) % 32'(N)) : '0;
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_port
        disp_region_port #(.N(N), .IW(IW), .RID(r), .TW(TW)) u_port (
            .clk      (clk),
            .rst      (rst),
            .pend     (pend),
            .tgt_q    (tgt_q),
            .insn_q   (insn_q),
            .start    (start_v[r]),
            .rdy      (reg_rdy[r]),
            .ack      (reg_ack[r]),
            .req      (reg_req[r]),
            .insn_out (reg_insn[r*IW +: IW]),
            .acc      (acc_r[r])
        );
    end

    a_r2_one_owner: assert property (@(posedge clk) disable iff (rst)
        $countones(acc_all) == $countones(reg_req & reg_ack))
        else $error("two channels acknowledged the same slot");

    a_r1_take_idle: assert property (@(posedge clk) disable iff (rst)
        (grp_take && pend != '0) |-> 1'b0)
        else $error("group taken while slots pending");

endmodule

// File: tb/sim_dispatch_arbiter.sv
module sim_dispatch_arbiter;
    localparam int N = 4, IW = 16, TW = 2, PW = 16, CW = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst, rand_en, grp_valid, grp_take, pc_adv;
    logic [N-1:0]    grp_slot_vld, reg_rdy, reg_ack, reg_req;
    logic [N*TW-1:0] grp_tgt;
    logic [N*IW-1:0] grp_insn, reg_insn;
    logic [PW-1:0]   fetch_pc;
    logic [CW-1:0]   pc_step;

    dispatch_arbiter #(.N(N), .IW(IW), .PC_W(PW)) u0 (
        .clk(clk), .rst(rst), .rand_en(rand_en), .grp_valid(grp_valid),
        .grp_slot_vld(grp_slot_vld), .grp_tgt(grp_tgt), .grp_insn(grp_insn),
        .grp_take(grp_take), .fetch_pc(fetch_pc), .pc_adv(pc_adv), .pc_step(pc_step),
        .reg_rdy(reg_rdy), .reg_ack(reg_ack), .reg_req(reg_req), .reg_insn(reg_insn)
    );

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected group model
    bit            g_live, g_done;
    logic [N-1:0]  g_vld;
    logic [TW-1:0] g_tgt [N];
    bit            dlv [N], ackd [N];
    int            last_slot [N];
    int            g_size, exp_pc, cd;
    bit            p_req [N], p_ack [N], p_rdy [N];
    logic [IW-1:0] p_dat [N];
    int            rand_nonasc, empty_done, stall, adv_cnt;
    bit            wd_fail;
    int            k_rdy, k_ack, k_grp, gmode, hold_r0;

    function automatic int popc(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += v[i];
        return c;
    endfunction

    task automatic make_group();
        int rr;
        rr = $urandom % N;
        for (int s = 0; s < N; s++) begin
            case (gmode)
                1: begin grp_slot_vld[s] = 1'b1; grp_tgt[s*TW +: TW] = TW'(rr); end
                2: begin grp_slot_vld[s] = 1'b0; grp_tgt[s*TW +: TW] = TW'($urandom); end
                3: begin grp_slot_vld[s] = 1'b1; grp_tgt[s*TW +: TW] = '0; end
                default: begin
                    grp_slot_vld[s] = 1'($urandom);
                    grp_tgt[s*TW +: TW] = TW'($urandom);
                end
            endcase
            grp_insn[s*IW +: IW] = {2'(s), 14'($urandom)};
        end
    endtask

    task automatic one_cycle();
        bit all_ok;
        int s;
        logic [IW-1:0] dat;
        @(negedge clk);
        // channel rules and routing
        for (int r = 0; r < N; r++) begin
            dat = reg_insn[r*IW +: IW];
            if (p_req[r] && p_ack[r]) begin
                if (reg_req[r]) chk(1'b0, "R5 request kept after ack", 1, 0);
            end else if (p_req[r]) begin
                chk(reg_req[r] && dat == p_dat[r], "R4 request/payload held", dat, p_dat[r]);
            end else if (reg_req[r]) begin
                s = int'(dat[IW-1 -: 2]);
                chk(p_rdy[r], "R3 request without ready", 0, 1);
                chk(g_live && g_vld[s] && !dlv[s] && g_tgt[s] == TW'(r),
                    "R2 routing/exactly-once", r, g_tgt[s]);
                dlv[s] = 1'b1;
                if (!rand_en) chk(s > last_slot[r], "R8 ascending order", s, last_slot[r] + 1);
                else if (s < last_slot[r]) rand_nonasc++;
                last_slot[r] = s;
            end
        end
        // completion timing and step
        chk(pc_adv == (cd == 1), "R7 completion cycle", pc_adv, cd == 1);
        if (cd > 0) cd--;
        if (pc_adv) begin
            all_ok = g_live;
            for (int i = 0; i < N; i++) if (g_vld[i] && !(dlv[i] && ackd[i])) all_ok = 1'b0;
            chk(all_ok, "R6 completion with pending slot", 0, 1);
            chk(pc_step == CW'(g_size), "R7 pc_step", pc_step, g_size);
            chk(fetch_pc == PW'(exp_pc + g_size), "R7 fetch_pc", fetch_pc, PW'(exp_pc + g_size));
            exp_pc = (exp_pc + g_size) & 16'hFFFF;
            if (g_size == 0) empty_done++;
            g_live = 1'b0;
            stall = 0;
            adv_cnt++;
        end else if (fetch_pc != PW'(exp_pc)) begin
            chk(1'b0, "R7 fetch_pc moved early", fetch_pc, exp_pc);
        end
        // drive next inputs
        for (int r = 0; r < N; r++) begin
            reg_rdy[r] = ($urandom % 100) < k_rdy;
            if (hold_r0 && r == 0) reg_rdy[r] = 1'b0;
            reg_ack[r] = reg_req[r] && (($urandom % 100) < k_ack);
            if (reg_ack[r]) ackd[int'(reg_insn[r*IW + IW - 2 +: 2])] = 1'b1;
            p_req[r] = reg_req[r];
            p_ack[r] = reg_ack[r];
            p_dat[r] = reg_insn[r*IW +: IW];
            p_rdy[r] = reg_rdy[r];
        end
        if (g_live && !g_done && g_size > 0) begin
            all_ok = 1'b1;
            for (int i = 0; i < N; i++) if (g_vld[i] && !ackd[i]) all_ok = 1'b0;
            if (all_ok) begin cd = 1; g_done = 1'b1; end
        end
        grp_valid = ($urandom % 100) < k_grp;
        make_group();
        #1;
        chk(grp_take == (!g_live && grp_valid), "R1 take condition", grp_take, !g_live && grp_valid);
        if (grp_take) begin
            g_live = 1'b1; g_done = 1'b0;
            g_vld  = grp_slot_vld;
            g_size = popc(grp_slot_vld);
            for (int i = 0; i < N; i++) begin
                g_tgt[i] = grp_tgt[i*TW +: TW];
                dlv[i] = 1'b0; ackd[i] = 1'b0; last_slot[i] = -1;
            end
            if (g_size == 0) begin cd = 2; g_done = 1'b1; end
        end
        stall++;
        if (stall > 3000 && !wd_fail) begin
            wd_fail = 1'b1;
            chk(1'b0, "watchdog: no group completed", stall, 0);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n && !wd_fail; i++) one_cycle();
    endtask

    task automatic drain();
        k_grp = 0; k_rdy = 100; k_ack = 100; hold_r0 = 0;
        run(40);
        chk(!g_live, "R6 drain completed", g_live, 0);
    endtask

    int adv_mark;

    initial begin
        rst = 1'b1; rand_en = 1'b0; grp_valid = 1'b0;
        grp_slot_vld = '0; grp_tgt = '0; grp_insn = '0; reg_rdy = '0; reg_ack = '0;
        g_live = 0; g_done = 0; exp_pc = 0; cd = 0; g_size = 0; g_vld = '0;
        rand_nonasc = 0; empty_done = 0; stall = 0; adv_cnt = 0; wd_fail = 0; hold_r0 = 0;
        for (int i = 0; i < N; i++) begin
            p_req[i] = 0; p_ack[i] = 0; p_rdy[i] = 0; p_dat[i] = '0;
            dlv[i] = 0; ackd[i] = 0; last_slot[i] = -1; g_tgt[i] = '0;
        end
        void'($urandom(32'd7331));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(reg_req == '0, "R10 reset requests", reg_req, 0);
        chk(fetch_pc == '0, "R10 reset fetch_pc", fetch_pc, 0);
        chk(!pc_adv, "R10 reset pc_adv", pc_adv, 0);
        rst = 1'b0;

        // deterministic, everyone ready
        gmode = 0; k_rdy = 100; k_ack = 100; k_grp = 100; run(300);
        // deterministic, sparse ready/ack
        k_rdy = 40; k_ack = 50; k_grp = 60; run(600);
        // deterministic, all slots compete for one region
        gmode = 1; k_rdy = 70; k_ack = 60; k_grp = 90; run(600);
        drain();
        // empty groups
        gmode = 2; k_grp = 100; run(20);
        chk(empty_done > 0, "R7 empty group completes with step 0", empty_done, 1);
        drain();
        // region 0 never ready: partial group must be retained
        gmode = 3; k_grp = 100; k_rdy = 100; k_ack = 100; hold_r0 = 1;
        run(10);
        adv_mark = adv_cnt;
        run(30);
        chk(adv_cnt == adv_mark, "R6 stalled group not completed", adv_cnt, adv_mark);
        chk(reg_req[0] == 1'b0, "R3 no request to unready region", reg_req[0], 0);
        drain();
        // randomized order, competing slots
        rand_en = 1'b1; gmode = 1; k_grp = 100; k_rdy = 100; k_ack = 100; run(600);
        chk(rand_nonasc > 0, "R9 randomized order seen", rand_nonasc, 1);
        // randomized, mixed traffic
        gmode = 0; k_rdy = 50; k_ack = 50; k_grp = 70; run(600);
        drain();
        rand_en = 1'b0;
        chk(adv_cnt > 100, "R7 groups completed overall", adv_cnt, 100);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule